// File: doc/BRIEF.md
# Watchdog and Clock-Fail Reset Supervisor

This unit decides when the core must restart and where it restarts from. Three causes can start a restart. The first is an external reset pin. The second is a software watchdog that expires when firmware stops servicing it. The third is a monitor that notices when the system clock has stopped toggling. None of these causes can be masked. A restart throws away all program state and saves nothing on any stack. The unit produces an active-high reset pulse of guaranteed minimum length, the 16-bit address of the vector byte pair that the core loads its start address from, and a code that records which cause fired last.

The unit runs entirely on a free-running reference clock `clk`. The monitored system clock enters as plain data on `mon_clk`, where it is synchronized and checked for transitions. A prescaler divides `clk` into slow reference ticks. If a set number of these ticks pass with no transition on the system clock, the monitor declares a failure. The watchdog counts `clk` cycles and is reloaded by a two-byte key sequence on a small service-write port. While the reset pulse is active, the watchdog and the clock monitor are both held cleared.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_n` is released, `rst_out` is 0, `rst_cause` is 2'b00 (no cause yet) and `vec_addr` is 16'hFFFE.
- R2: A low level on `pin_rst_n` is seen after a two-flop synchronizer. `rst_out` rises 3 clock edges after the first cycle `pin_rst_n` is driven low. The unit then reports `rst_cause` 2'b01 and `vec_addr` 16'hFFFE. For a low level lasting L cycles, `rst_out` stays high for L + HOLD_CYCLES - 1 cycles.
- R3: While `wdt_en` is 1, a watchdog that is not serviced expires. `rst_out` rises WDT_LOAD + 1 edges after the edge that accepted the last valid service. The unit then reports `rst_cause` 2'b10 and `vec_addr` 16'hFFFA.
- R4: A write of 8'h55 followed directly by a write of 8'hAA (the next write on `svc_wr`) reloads the watchdog count to WDT_LOAD. Servicing more often than every WDT_LOAD cycles never causes a reset.
- R5: Any other write order leaves the count unchanged. This covers an 8'hAA with no 8'h55 in front of it, and an 8'h55 followed by another value and then 8'hAA. The expiry time stays the same as before those writes.
- R6: When the system clock stops toggling, the unit reports `rst_cause` 2'b11 and `vec_addr` 16'hFFFC. While the system clock keeps toggling, this cause never fires.
- R7: The clock failure is declared after CM_TICKS reference ticks (one tick every REF_DIV cycles) with no system-clock transition. `rst_out` rises between (CM_TICKS-1)*REF_DIV + 3 and CM_TICKS*REF_DIV + 6 cycles after the last transition driven on `mon_clk`.
- R8: A watchdog or clock-fail reset holds `rst_out` high for exactly HOLD_CYCLES cycles. No pulse is ever shorter than HOLD_CYCLES. While `rst_out` is high, neither the watchdog nor the clock monitor raises a new cause.
- R9: When causes arrive on the same edge, the pin cause wins over both others, and the clock-fail cause wins over the watchdog.
- R10: While `wdt_en` is 0, the watchdog never causes a reset, however much time passes.
- R11: `rst_cause` and `vec_addr` keep their values after `rst_out` falls. They change only when a new cause fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous power-on reset of the unit, active low |
| pin_rst_n | input | 1 | External reset request, active low, asynchronous |
| mon_clk | input | 1 | System clock under watch, sampled as data |
| wdt_en | input | 1 | Watchdog enable |
| svc_wr | input | 1 | Service-register write strobe |
| svc_data | input | 8 | Service-register write data |
| rst_out | output | 1 | Reset to the core, active high |
| vec_addr | output | 16 | Address of the vector pair for the restart |
| rst_cause | output | 2 | Last cause: 00 none, 01 pin, 10 watchdog, 11 clock fail |

## Verification
A wrong internal state shows up at the ports in one of two ways. A watchdog count that is off by even one, or a key-sequence flag left armed, moves the rising edge of `rst_out` away from exactly WDT_LOAD + 1 cycles after the accepted service. The bench detects that shift at the edge where the reset was due. A faulty priority pick or vector choice shows up in the first cycle of the pulse as a wrong `rst_cause`/`vec_addr` pair. A pulse counter that is loaded or decremented wrongly shows up when `rst_out` falls, as a width different from the one expected. A clock monitor that fires with the clock still toggling shows up as a reset the bench did not expect, within a few reference ticks.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_WDOG = 2'd2,
    CAUSE_CLKF = 2'd3
  } cause_e;

  localparam logic [15:0] VEC_PIN  = 16'hFFFE;
  localparam logic [15:0] VEC_WDOG = 16'hFFFA;
  localparam logic [15:0] VEC_CLKF = 16'hFFFC;

  // Fixed priority: pin first, then clock fail, then watchdog.
  function automatic cause_e pick_cause(input logic pin, input logic clkf, input logic wdog);
    if (pin)       return CAUSE_PIN;
    else if (clkf) return CAUSE_CLKF;
    else if (wdog) return CAUSE_WDOG;
    else           return CAUSE_NONE;
  endfunction

  function automatic logic [15:0] vector_of(input cause_e c);
    case (c)
      CAUSE_WDOG: return VEC_WDOG;
      CAUSE_CLKF: return VEC_CLKF;
      default:    return VEC_PIN;
    endcase
  endfunction

  // One step of a saturating down-counter with reload.
  function automatic int unsigned count_down(input int unsigned cur, input logic reload,
                                             input int unsigned load);
    if (reload)        return load;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_mon.sv
module clk_mon #(
  parameter int REF_DIV    = 4,
  parameter int FAIL_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_lvl,
  input  logic hold,
  output logic fail
);
  localparam int DIV_W  = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int IDLE_W = $clog2(FAIL_TICKS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(REF_DIV - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(FAIL_TICKS);

  logic              prev;
  logic [DIV_W-1:0]  pres;
  logic [IDLE_W-1:0] idle;
  logic              mon_edge;
  logic              ref_tick;

  assign mon_edge = mon_lvl ^ prev;
  assign ref_tick = (pres == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pres <= '0;
      idle <= '0;
    end else begin
      prev <= mon_lvl;
      pres <= ref_tick ? '0 : pres + 1'b1;
      if (hold || mon_edge)                idle <= '0;
      else if (ref_tick && idle != IDLE_MAX) idle <= idle + 1'b1;
    end
  end

  assign fail = !hold && (idle == IDLE_MAX);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import rst_sup_pkg::*;
#(
  parameter int         LOAD  = 64,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       hold,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       expire
);
  localparam int CW = $clog2(LOAD + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          refresh;
  logic          reload;

  assign refresh = wr && armed && (wdata == KEY_B) && !hold;
  assign reload  = hold || !en || refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= CW'(LOAD);
    end else begin
      if (hold)    armed <= 1'b0;
      else if (wr) armed <= (wdata == KEY_A);
      cnt <= CW'(count_down(32'(cnt), reload, LOAD));
    end
  end

  assign expire = en && !hold && (cnt == '0);
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse
  import rst_sup_pkg::*;
#(
  parameter int HOLD = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_req,
  input  logic        clkf,
  input  logic        wdog,
  output logic        rst_out,
  output cause_e      cause,
  output logic [15:0] vec,
  output logic        load
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt;
  cause_e        pick;

  assign load = pin_req | clkf | wdog;
  assign pick = pick_cause(pin_req, clkf, wdog);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cause <= CAUSE_NONE;
      vec   <= VEC_PIN;
    end else if (load) begin
      cnt   <= HW'(HOLD);
      cause <= pick;
      vec   <= vector_of(pick);
    end else begin
      cnt <= HW'(count_down(32'(cnt), 1'b0, HOLD));
    end
  end

  assign rst_out = (cnt != '0);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WDT_LOAD    = 64,
  parameter int REF_DIV     = 4,
  parameter int CM_TICKS    = 8,
  parameter int HOLD_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_rst_n,
  input  logic        mon_clk,
  input  logic        wdt_en,
  input  logic        svc_wr,
  input  logic [7:0]  svc_data,
  output logic        rst_out,
  output logic [15:0] vec_addr,
  output logic [1:0]  rst_cause
);
  logic   pin_lvl;
  logic   mon_lvl;
  logic   pin_evt;
  logic   cm_fail;
  logic   wdt_expire;
  logic   pulse_load;
  cause_e cause_q;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_rst_n), .q(pin_lvl)
  );
  assign pin_evt = ~pin_lvl;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mon_sync (
    .clk(clk), .rst_n(rst_n), .d(mon_clk), .q(mon_lvl)
  );

  clk_mon #(.REF_DIV(REF_DIV), .FAIL_TICKS(CM_TICKS)) u_clk_mon (
    .clk(clk), .rst_n(rst_n), .mon_lvl(mon_lvl), .hold(rst_out), .fail(cm_fail)
  );

  wdt_core #(.LOAD(WDT_LOAD)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .hold(rst_out),
    .wr(svc_wr), .wdata(svc_data), .expire(wdt_expire)
  );

  rst_pulse #(.HOLD(HOLD_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_evt), .clkf(cm_fail), .wdog(wdt_expire),
    .rst_out(rst_out), .cause(cause_q), .vec(vec_addr), .load(pulse_load)
  );

  assign rst_cause = cause_q;
endmodule

module rst_supervisor_chk
  import rst_sup_pkg::*;
#(
  parameter int HOLD = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_out,
  input logic [1:0]  rst_cause,
  input logic [15:0] vec_addr,
  input logic        pin_evt,
  input logic        cm_fail,
  input logic        wdt_expire,
  input logic        pulse_load
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= 0;
    else if (rst_out) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= 0;
  end

  // R2 and R9: the pin wins
  assert_pin_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |=> rst_out && rst_cause == 2'b01 && vec_addr == 16'hFFFE);

  // R6, with R9 ordering over the watchdog
  assert_clkfail_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cm_fail && !pin_evt |=> rst_out && rst_cause == 2'b11 && vec_addr == 16'hFFFC);

  assert_wdog_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_expire && !cm_fail && !pin_evt |=> rst_out && rst_cause == 2'b10 && vec_addr == 16'hFFFA);

  assert_quiet_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !wdt_expire && !cm_fail);

  assert_min_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> hi_cnt >= HOLD);

  assert_load_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_load |=> rst_out);

  assert_cause_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_load |=> $stable(rst_cause) && $stable(vec_addr));
endmodule

bind rst_supervisor rst_supervisor_chk #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_out(rst_out), .rst_cause(rst_cause),
  .vec_addr(vec_addr), .pin_evt(pin_evt), .cm_fail(cm_fail),
  .wdt_expire(wdt_expire), .pulse_load(pulse_load)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int LOAD  = 64;
  localparam int DIV   = 4;
  localparam int TICKS = 8;
  localparam int HOLD  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_rst_n = 1'b1;
  logic       mon_clk = 1'b0;
  logic       wdt_en = 1'b0;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_data = 8'h00;
  wire        rst_out;
  wire [15:0] vec_addr;
  wire [1:0]  rst_cause;

  rst_supervisor #(.WDT_LOAD(LOAD), .REF_DIV(DIV), .CM_TICKS(TICKS), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .mon_clk(mon_clk), .wdt_en(wdt_en),
    .svc_wr(svc_wr), .svc_data(svc_data), .rst_out(rst_out), .vec_addr(vec_addr),
    .rst_cause(rst_cause)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // system clock under watch: toggles every 3 reference cycles while running
  bit mon_run = 1'b1;
  int mdiv = 0;
  int last_tog = 0;
  always @(negedge clk) begin
    if (mon_run) begin
      if (mdiv == 2) begin
        mdiv <= 0;
        mon_clk <= ~mon_clk;
        last_tog <= cyc;
      end else begin
        mdiv <= mdiv + 1;
      end
    end
  end

  // scoreboard of expected pulses
  string q_req[$];
  int    q_cause[$], q_vec[$], q_lo[$], q_hi[$], q_w[$];
  int    done_cnt = 0;

  task automatic expect_pulse(input string req, input int cause, input int vec,
                              input int lo, input int hi, input int w);
    q_req.push_back(req); q_cause.push_back(cause); q_vec.push_back(vec);
    q_lo.push_back(lo); q_hi.push_back(hi); q_w.push_back(w);
  endtask

  task automatic wait_done(input int n);
    wait (done_cnt >= n);
  endtask

  // monitor
  bit prev_r = 1'b0;
  int rise_c = 0;
  int rc = 0;
  int rv = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_out && !prev_r) begin
        rise_c = cyc; rc = int'(rst_cause); rv = int'(vec_addr);
      end
      if (!rst_out && prev_r) begin
        if (q_req.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 R10 unexpected reset pulse at cycle %0d actual=1 expected=0", rise_c);
        end else begin
          string r;
          r = q_req.pop_front();
          check({r, " cause"}, rc, q_cause.pop_front());
          check({r, " vector"}, rv, q_vec.pop_front());
          check_rng({r, " rise cycle"}, rise_c, q_lo.pop_front(), q_hi.pop_front());
          check({r, " R8 width"}, cyc - rise_c, q_w.pop_front());
          check({r, " R11 cause kept at release"}, int'(rst_cause), rc);
        end
        done_cnt++;
      end
    end
    prev_r = rst_out;
  end

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); svc_wr = 1'b1; svc_data = b;
    @(negedge clk); svc_wr = 1'b0;
  endtask

  // returns the edge index on which 8'hAA lands
  task automatic service(output int r);
    @(negedge clk); svc_wr = 1'b1; svc_data = 8'h55;
    @(negedge clk); svc_data = 8'hAA; r = cyc + 1;
    @(negedge clk); svc_wr = 1'b0;
  endtask

  initial begin : driver
    int c;
    int r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst_out", int'(rst_out), 0);
    check("R1 cause", int'(rst_cause), 0);
    check("R1 vector", int'(vec_addr), 16'hFFFE);

    // R2: pin held low for 3 cycles
    @(negedge clk); c = cyc; pin_rst_n = 1'b0;
    expect_pulse("R2", 1, 16'hFFFE, c + 3, c + 3, 3 + HOLD - 1);
    repeat (3) @(negedge clk);
    pin_rst_n = 1'b1;
    wait_done(1);
    repeat (20) @(negedge clk);
    check("R11 cause after pin", int'(rst_cause), 1);

    // R4: periodic service keeps the watchdog quiet
    @(negedge clk); wdt_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      service(r);
      repeat (40) @(negedge clk);
    end
    check("R4 no reset while serviced", int'(rst_out), 0);
    check("R4 pulse count", done_cnt, 1);

    // R3: stop servicing
    service(r);
    expect_pulse("R3", 2, 16'hFFFA, r + LOAD + 1, r + LOAD + 1, HOLD);
    wait_done(2);
    wdt_en = 1'b0;

    // R5: bad sequences leave the count alone
    @(negedge clk); wdt_en = 1'b1;
    service(r);
    repeat (10) @(negedge clk);
    wr_byte(8'hAA);
    repeat (5) @(negedge clk);
    svc_wr = 1'b1; svc_data = 8'h55;
    @(negedge clk); svc_data = 8'h33;
    @(negedge clk); svc_data = 8'hAA;
    @(negedge clk); svc_wr = 1'b0;
    expect_pulse("R5", 2, 16'hFFFA, r + LOAD + 1, r + LOAD + 1, HOLD);
    wait_done(3);
    wdt_en = 1'b0;

    // R9: pin and watchdog land on the same edge
    @(negedge clk); wdt_en = 1'b1;
    service(r);
    while (cyc != r + LOAD - 2) @(negedge clk);
    c = cyc; pin_rst_n = 1'b0;
    expect_pulse("R9", 1, 16'hFFFE, c + 3, c + 3, 2 + HOLD - 1);
    repeat (2) @(negedge clk);
    pin_rst_n = 1'b1;
    wait_done(4);
    wdt_en = 1'b0;

    // R10: disabled watchdog stays silent
    repeat (300) @(negedge clk);
    check("R10 no reset while disabled", int'(rst_out), 0);
    check("R10 pulse count", done_cnt, 4);

    // R6 R7: stop the system clock
    @(negedge clk); mon_run = 1'b0;
    repeat (2) @(negedge clk);
    c = last_tog;
    expect_pulse("R6 R7", 3, 16'hFFFC, c + 3 + (TICKS - 1) * DIV, c + 6 + TICKS * DIV, HOLD);
    wait_done(5);
    mon_run = 1'b1;
    repeat (50) @(negedge clk);
    check("R11 cause after clock fail", int'(rst_cause), 3);
    check("R11 vector after clock fail", int'(vec_addr), 16'hFFFC);
    check("R6 no reset with clock running", int'(rst_out), 0);
    check("R6 pending pulses", q_req.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL run hung: actual cycle=%0d expected below %0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule